// File: doc/BRIEF.md
# System Time Counters

This block keeps three free-running time bases from a single reference clock. The first is a wide timestamp that is normally 56 bits. The second counts microseconds. The third counts cycles of a nominal oscillator. Each base has its own fractional prescaler: an accumulator adds a numerator every reference cycle and emits a tick each time the sum reaches the denominator. With a 200 MHz reference, the default ratios are 5/32 for the timestamp, giving 31.25 MHz. They are 1/200 for the microsecond count and 24/125 for the oscillator count, giving 38.4 MHz. Every counter runs from reset, never stops and wraps at its width.

Software reads the counters through a simple registered read port with fixed word offsets. The timestamp is wider than one data word, so it is split into a low window and a high window. Reading one window does not hold the other. To get a consistent value, a reader reads the high window, then the low window, then the high window again. It repeats this until both high reads agree.

Top module: `sys_time_counters`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, every counter is zero and the read data output is zero.
- R2: After n reference cycles since reset release, the timestamp count equals floor(n * TS_NUM / TS_DEN). The defaults are 5/32, which is 31.25 MHz from a 200 MHz reference. The prescaler remainder always stays below its denominator.
- R3: After n reference cycles, the microsecond count equals floor(n * US_NUM / US_DEN). The default is 1/200.
- R4: After n reference cycles, the oscillator count equals floor(n * OSC_NUM / OSC_DEN). The default is 24/125.
- R5: Each counter wraps modulo 2 to the power of its own width and carries on counting from zero.
- R6: Offset 0x000 returns the low TS_LO_W bits of the timestamp, zero-extended. Offset 0x004 returns the remaining upper TS_W - TS_LO_W bits, zero-extended. Bits above that field read as zero.
- R7: Offset 0x008 returns the microsecond count and offset 0x00C returns the oscillator count, both zero-extended. Every other address, including unaligned ones, returns zero.
- R8: Read data appears in the cycle after the address is presented. It holds the value the selected counter had at the clock edge that sampled the address.
- R9: The two timestamp windows are not captured together. A high-low-high read sequence, repeated until both high reads match, returns the exact timestamp at the low read. Such assembled values never decrease across a wrap of the low window.
- R10: A counter changes by at most one step per reference cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; all counters and prescalers run on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr | input | ADDR_W | Byte offset of the register to read |
| rd_data | output | 32 | Registered read data for the offset presented in the previous cycle |

## Verification
The bench runs two instances, each against a behavioural model of the counts. The first uses the full widths and default rates. The second uses narrow counters and fast rates, so the low window, the microsecond count and the oscillator count all wrap within the run. A sweep over mapped, unmapped and unaligned offsets separates address decode faults from rate faults. It also shows any wrong zero-extension of the high window. A long stretch on one offset catches counters that jump by more than one step. Repeated high-low-high reads on the narrow instance must hit torn reads and retry. This shows that the windows are not captured together and that the retry rule yields exact, non-decreasing values.

// File: rtl/sys_time_pkg.sv
package sys_time_pkg;

    localparam int WORD_W = 32;

    // Byte offsets of the read windows
    localparam logic [31:0] OFS_TS_LO = 32'h0000_0000;
    localparam logic [31:0] OFS_TS_HI = 32'h0000_0004;
    localparam logic [31:0] OFS_USEC  = 32'h0000_0008;
    localparam logic [31:0] OFS_OSC   = 32'h0000_000C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TS_LO,
        SEL_TS_HI,
        SEL_USEC,
        SEL_OSC
    } rd_sel_e;

    // Full-address match: unaligned or unknown offsets select nothing
    function automatic rd_sel_e decode_offset(input logic [31:0] ofs);
        rd_sel_e sel;
        case (ofs)
            OFS_TS_LO: sel = SEL_TS_LO;
            OFS_TS_HI: sel = SEL_TS_HI;
            OFS_USEC:  sel = SEL_USEC;
            OFS_OSC:   sel = SEL_OSC;
            default:   sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/stc_frac_tick.sv
// Fractional prescaler: emits NUM ticks every DEN reference cycles, evenly spread.
// Requires 1 <= NUM <= DEN.
module stc_frac_tick #(
    parameter int NUM = 1,
    parameter int DEN = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int ACC_W = $clog2(2 * DEN + 1);
    localparam logic [ACC_W-1:0] NUM_V = ACC_W'(NUM);
    localparam logic [ACC_W-1:0] DEN_V = ACC_W'(DEN);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic [ACC_W-1:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = st_q.acc + NUM_V;
        tick = (sum >= DEN_V);
        if (tick) begin
            st_d.acc = sum - DEN_V;
        end else begin
            st_d.acc = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.acc < DEN_V);

endmodule

// File: rtl/stc_free_counter.sv
// Free-running up counter that wraps at its width.
module stc_free_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inc) begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

    // R10
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == $past(st_q.cnt)) || (st_q.cnt == $past(st_q.cnt) + ONE));

endmodule

// File: rtl/stc_channel.sv
// One time base: prescaler feeding a wrapping counter.
module stc_channel #(
    parameter int W   = 32,
    parameter int NUM = 1,
    parameter int DEN = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);
    logic tick;

    stc_frac_tick #(
        .NUM(NUM),
        .DEN(DEN)
    ) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    stc_free_counter #(
        .W(W)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (tick),
        .count(count)
    );

endmodule

// File: rtl/stc_read_port.sv
// Registered read mux over the counter windows.
module stc_read_port
    import sys_time_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int TS_W    = 56,
    parameter int TS_LO_W = 32,
    parameter int US_W    = 32,
    parameter int OSC_W   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic [TS_W-1:0]      ts_cnt,
    input  logic [US_W-1:0]      us_cnt,
    input  logic [OSC_W-1:0]     osc_cnt,
    output logic [WORD_W-1:0]    rd_data
);
    localparam int HI_W = TS_W - TS_LO_W;
    localparam logic [WORD_W-1:0] HI_MASK = WORD_W'((64'd1 << HI_W) - 64'd1);

    typedef struct packed {
        logic [WORD_W-1:0] data;
    } rd_st_t;

    rd_st_t st_d, st_q;
    rd_sel_e sel;
    logic [WORD_W-1:0] lo_word, hi_word, us_word, osc_word;

    always_comb begin
        lo_word  = WORD_W'(ts_cnt[TS_LO_W-1:0]);
        hi_word  = WORD_W'(ts_cnt[TS_W-1:TS_LO_W]);
        us_word  = WORD_W'(us_cnt);
        osc_word = WORD_W'(osc_cnt);
        sel      = decode_offset(WORD_W'(rd_addr));
        st_d     = st_q;
        case (sel)
            SEL_TS_LO: st_d.data = lo_word;
            SEL_TS_HI: st_d.data = hi_word;
            SEL_USEC:  st_d.data = us_word;
            SEL_OSC:   st_d.data = osc_word;
            default:   st_d.data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.data;

    // R7
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |=> (rd_data == '0));

    // R6
    hi_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_TS_HI) |=> ((rd_data & ~HI_MASK) == '0));

endmodule

// File: rtl/sys_time_counters.sv
// Three free-running time bases with a registered read port.
// Constraints: TS_LO_W < TS_W, TS_W - TS_LO_W <= 32, US_W and OSC_W <= 32,
// 1 <= NUM <= DEN for each channel, ADDR_W between 4 and 32.
module sys_time_counters
    import sys_time_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int TS_W    = 56,
    parameter int TS_LO_W = 32,
    parameter int US_W    = 32,
    parameter int OSC_W   = 32,
    parameter int TS_NUM  = 5,
    parameter int TS_DEN  = 32,
    parameter int US_NUM  = 1,
    parameter int US_DEN  = 200,
    parameter int OSC_NUM = 24,
    parameter int OSC_DEN = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data
);
    logic [TS_W-1:0]  ts_cnt;
    logic [US_W-1:0]  us_cnt;
    logic [OSC_W-1:0] osc_cnt;

    stc_channel #(.W(TS_W), .NUM(TS_NUM), .DEN(TS_DEN)) u_ts (
        .clk  (clk),
        .rst_n(rst_n),
        .count(ts_cnt)
    );

    stc_channel #(.W(US_W), .NUM(US_NUM), .DEN(US_DEN)) u_us (
        .clk  (clk),
        .rst_n(rst_n),
        .count(us_cnt)
    );

    stc_channel #(.W(OSC_W), .NUM(OSC_NUM), .DEN(OSC_DEN)) u_osc (
        .clk  (clk),
        .rst_n(rst_n),
        .count(osc_cnt)
    );

    stc_read_port #(
        .ADDR_W (ADDR_W),
        .TS_W   (TS_W),
        .TS_LO_W(TS_LO_W),
        .US_W   (US_W),
        .OSC_W  (OSC_W)
    ) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_addr(rd_addr),
        .ts_cnt (ts_cnt),
        .us_cnt (us_cnt),
        .osc_cnt(osc_cnt),
        .rd_data(rd_data)
    );

    // R8
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(OFS_OSC)) |=> (rd_data == WORD_W'($past(osc_cnt))));

endmodule

// File: tb/sys_time_counters_tb_top.sv
`timescale 1ns/1ps
module sys_time_counters_tb_top;

    localparam int MAX_CYC = 200000;

    // Wide instance (defaults)
    localparam int M_TS_W = 56, M_LO_W = 32, M_US_W = 32, M_OSC_W = 32;
    localparam int M_TN = 5, M_TD = 32, M_UN = 1, M_UD = 200, M_ON = 24, M_OD = 125;
    // Narrow instance: fast wraps
    localparam int W_TS_W = 20, W_LO_W = 8, W_US_W = 8, W_OSC_W = 10;
    localparam int W_TN = 1, W_TD = 1, W_UN = 1, W_UD = 3, W_ON = 2, W_OD = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data_m, rd_data_w;

    int checks = 0;
    int failures = 0;
    longint unsigned edges = 0;

    always #2.5 clk = ~clk;

    sys_time_counters dut_i (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data_m)
    );

    sys_time_counters #(
        .TS_W(W_TS_W), .TS_LO_W(W_LO_W), .US_W(W_US_W), .OSC_W(W_OSC_W),
        .TS_NUM(W_TN), .TS_DEN(W_TD), .US_NUM(W_UN), .US_DEN(W_UD),
        .OSC_NUM(W_ON), .OSC_DEN(W_OD)
    ) dut_w_i (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data_w)
    );

    // Ideal count after n cycles: floor(n*num/den) mod 2^w (R2, R3, R4, R5)
    function automatic longint unsigned model_cnt(input longint unsigned n,
            input int num, input int den, input int w);
        longint unsigned v;
        v = (n * longint'(num)) / longint'(den);
        return v & ((64'd1 << w) - 64'd1);
    endfunction

    function automatic longint unsigned model_ts(input int inst, input longint unsigned n);
        if (inst == 0) return model_cnt(n, M_TN, M_TD, M_TS_W);
        return model_cnt(n, W_TN, W_TD, W_TS_W);
    endfunction

    // Expected read word for an offset given n cycles before the sampling edge (R6, R7)
    function automatic logic [31:0] model_rd(input int inst, input logic [11:0] a,
            input longint unsigned n);
        int lw, uw, ow, un, ud, on, od;
        longint unsigned ts;
        if (inst == 0) begin
            lw = M_LO_W; uw = M_US_W; ow = M_OSC_W; un = M_UN; ud = M_UD; on = M_ON; od = M_OD;
        end else begin
            lw = W_LO_W; uw = W_US_W; ow = W_OSC_W; un = W_UN; ud = W_UD; on = W_ON; od = W_OD;
        end
        ts = model_ts(inst, n);
        case (a)
            12'h000: return 32'(ts & ((64'd1 << lw) - 64'd1));
            12'h004: return 32'(ts >> lw);
            12'h008: return 32'(model_cnt(n, un, ud, uw));
            12'h00C: return 32'(model_cnt(n, on, od, ow));
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [11:0] a);
        case (a)
            12'h000, 12'h004: return "R6";
            12'h008:          return "R3";
            12'h00C:          return "R4";
            default:          return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // One cycle: present address, clock, compare both instances (R8: one-cycle latency)
    task automatic step(input logic [11:0] a);
        logic [31:0] em, ew;
        string t;
        rd_addr = a;
        @(posedge clk);
        if (rst_n) edges++;
        @(negedge clk);
        if (rst_n) begin
            em = model_rd(0, a, edges - 1);
            ew = model_rd(1, a, edges - 1);
            t  = tag_of(a);
        end else begin
            em = '0; ew = '0; t = "R1";
        end
        check(t, rd_data_m, em);
        check(t, rd_data_w, ew);
    endtask

    // High-low-high retry read (R9)
    task automatic retry_read(input int inst, output longint unsigned val,
            output longint unsigned exp_v, output int retries);
        logic [31:0] h1, lo, h2;
        int lw;
        lw = (inst == 0) ? M_LO_W : W_LO_W;
        retries = 0;
        forever begin
            step(12'h004);
            h1 = (inst == 0) ? rd_data_m : rd_data_w;
            step(12'h000);
            lo = (inst == 0) ? rd_data_m : rd_data_w;
            exp_v = model_ts(inst, edges - 1);
            step(12'h004);
            h2 = (inst == 0) ? rd_data_m : rd_data_w;
            if (h1 == h2) break;
            retries++;
        end
        val = (longint'(h2) << lw) | longint'(lo);
    endtask

    initial begin
        #(MAX_CYC * 5.0);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [11:0] sweep [8];
        longint unsigned v, ev, prev;
        int r, total_retries;
        logic [31:0] last_osc;

        sweep = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'hFFC, 12'h002, 12'h7F0};

        // R1: reset state on every window
        for (int i = 0; i < 4; i++) step(sweep[i]);
        @(negedge clk);
        rst_n = 1'b1;

        // Sweep mapped, unmapped and unaligned offsets; covers R2..R8 and
        // the narrow instance wraps (R5)
        for (int i = 0; i < 3000; i++) step(sweep[i % 8]);

        // R10: the oscillator count never moves more than one step per cycle
        step(12'h00C);
        last_osc = rd_data_w;
        for (int i = 0; i < 1600; i++) begin
            step(12'h00C);
            check("R10", 32'((rd_data_w - last_osc) & 32'h3FF) <= 32'd1 ? 32'd1 : 32'd0, 32'd1);
            last_osc = rd_data_w;
        end

        // R9: retry reads on narrow instance across many low-window wraps
        total_retries = 0;
        prev = 0;
        for (int i = 0; i < 2000; i++) begin
            retry_read(1, v, ev, r);
            total_retries += r;
            check("R9", 32'(v), 32'(ev));
            check("R9", (v >= prev) ? 32'd1 : 32'd0, 32'd1);
            prev = v;
        end
        // R9: halves are not captured together, so torn reads must occur
        check("R9", (total_retries > 0) ? 32'd1 : 32'd0, 32'd1);

        // R9 on the wide instance
        prev = 0;
        for (int i = 0; i < 200; i++) begin
            retry_read(0, v, ev, r);
            check("R9", 32'(v), 32'(ev));
            check("R9", 32'(v >> 32), 32'(ev >> 32));
            check("R9", (v >= prev) ? 32'd1 : 32'd0, 32'd1);
            prev = v;
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule